// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio P×N + A. A dual-modulus prescaler counts either P or P+1 input clocks per turn. A swallow counter loaded with A keeps the prescaler on P+1 for the first A turns, and a main counter loaded with N ends the whole output period after N turns. Each period ends with a one-clock comparison pulse `fp`. The base modulus P can be the narrow value (2^PRE_LOG) or the wide value (2^(PRE_LOG+1)).

A second counter sits in the same clock domain and divides a stream of oscillator ticks (`ref_ce` strobes) by R. It emits one reference pulse `fr` for every R ticks. The ratios come from static configuration inputs. They are captured only at reset and at the end of a period, so a change never cuts a period short. A swallow value that is not below N is reduced to N−1, and a flag reports that the active ratio was clamped.

Top module: `swallow_divider`

## Requirements
- R1: While reset is high and on the first clock after it, `fp` and `fr` are low.
- R2: With `cfg_narrow`=1 the base modulus P is 2^PRE_LOG. With `cfg_narrow`=0, P is 2^(PRE_LOG+1).
- R3: In steady operation, consecutive rising edges of `fp` are exactly P×N + A' input clocks apart. A' is the effective swallow count.
- R4: `fp` is high for exactly one clock per period.
- R5: If `cfg_swallow` ≥ `cfg_main` when the ratio is captured, A' = N−1 and `swallow_clamped` is 1. Otherwise A' = `cfg_swallow` and `swallow_clamped` is 0. The flag describes the ratio currently in use.
- R6: A change of the divider configuration during a period has no effect on that period, including its length and the flag. The new ratio applies from the next period onward.
- R7: After reset is released, the first `fp` pulse appears P×N + A' clocks later. The count includes the first clock with reset low.
- R8: `fr` rises one clock after every R-th clock on which `ref_ce` is high, is one clock wide, and counts from reset.
- R9: A change of `cfg_ref` takes effect only after the current run of R ticks completes.
- R10: With `ref_ce` held low, `fr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset; also captures all ratios |
| ref_ce | input | 1 | Oscillator tick strobe for the reference counter |
| cfg_narrow | input | 1 | 1 selects P = 2^PRE_LOG, 0 selects P = 2^(PRE_LOG+1) |
| cfg_swallow | input | A_W | Swallow count A |
| cfg_main | input | N_W | Main count N (3 or more) |
| cfg_ref | input | R_W | Reference ratio R (3 or more) |
| fp | output | 1 | One-clock pulse at the end of each divided period |
| fr | output | 1 | One-clock pulse every R reference ticks |
| swallow_clamped | output | 1 | Active ratio had its swallow count reduced to N−1 |

## Verification
The assertions assume that `cfg_main` and `cfg_ref` are never below 3. Otherwise the main and reference down-counters could be loaded with zero, and the one-clock-wide pulse properties would not hold. The stimulus keeps to this by sweeping N from 3 to its maximum and R from 3 upward, while A runs over its whole range, so clamping is exercised deliberately. Configuration changes are applied away from clock edges, in the middle of a period, so the capture at the period boundary is tested.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic {
        MOD_WIDE   = 1'b0,
        MOD_NARROW = 1'b1
    } pre_mode_e;

    typedef struct packed {
        pre_mode_e mode;
        logic      clamped;
    } ratio_flags_t;

    // Prescaler turn length: base modulus plus one while swallowing.
    function automatic int unsigned turn_length(int unsigned log2p, pre_mode_e m, logic extra);
        int unsigned base;
        base = (m == MOD_NARROW) ? (32'd1 << log2p) : (32'd1 << (log2p + 1));
        return base + {31'd0, extra};
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler import psd_pkg::*; #(
    parameter int PRE_LOG = 6,
    localparam int CW = PRE_LOG + 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pre_mode_e mode,
    input  logic      swallow,
    output logic      turn_done
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] last_val;

    assign last_val  = CW'(turn_length(PRE_LOG, mode, swallow) - 1);
    assign turn_done = (cnt == last_val);

    always_ff @(posedge clk) begin
        if (rst || turn_done) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    // R3: count never runs past the current turn length
    a_r3_count_within_turn: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_val);

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr import psd_pkg::*; #(
    parameter int A_W = 7,
    parameter int N_W = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           turn_done,
    input  pre_mode_e      ld_mode,
    input  logic           ld_clamped,
    input  logic [A_W-1:0] ld_a,
    input  logic [N_W-1:0] ld_n,
    output logic           swallow,
    output pre_mode_e      mode,
    output logic           clamped,
    output logic           period_pulse
);
    logic [A_W-1:0] a_left;
    logic [N_W-1:0] n_left;
    ratio_flags_t   flags;
    logic           last_turn;

    assign last_turn = turn_done && (n_left == N_W'(1));
    assign swallow   = (a_left != '0);
    assign mode      = flags.mode;
    assign clamped   = flags.clamped;

    always_ff @(posedge clk) begin
        if (rst || last_turn) begin
            a_left <= ld_a;
            n_left <= ld_n;
            flags  <= '{mode: ld_mode, clamped: ld_clamped};
        end else if (turn_done) begin
            n_left <= n_left - N_W'(1);
            if (a_left != '0) a_left <= a_left - A_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) period_pulse <= 1'b0;
        else     period_pulse <= last_turn;
    end

    // R5: swallow turns left always fewer than main turns left
    a_r5_swallow_below_main: assert property (@(posedge clk) disable iff (rst)
        int'(a_left) < int'(n_left));

    // R3: main counter never sits at zero
    a_r3_main_nonzero: assert property (@(posedge clk) disable iff (rst)
        n_left != '0);

    // R6: active modulus and flag only change at a period end
    a_r6_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
        !last_turn |=> $stable(flags));

    // R4: period pulse is one clock wide
    a_r4_fp_single: assert property (@(posedge clk) disable iff (rst)
        period_pulse |=> !period_pulse);

endmodule

// File: rtl/psd_ref_ctr.sv
module psd_ref_ctr #(
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [R_W-1:0] ld_r,
    output logic           ref_pulse
);
    logic [R_W-1:0] r_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_left    <= ld_r;
            ref_pulse <= 1'b0;
        end else if (tick) begin
            if (r_left == R_W'(1)) begin
                r_left    <= ld_r;
                ref_pulse <= 1'b1;
            end else begin
                r_left    <= r_left - R_W'(1);
                ref_pulse <= 1'b0;
            end
        end else begin
            ref_pulse <= 1'b0;
        end
    end

    // R10: a reference pulse always follows a tick
    a_r10_fr_after_tick: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> $past(tick));

    // R8: reference pulse is one clock wide
    a_r8_fr_single: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);

    // R9: remaining count never drops to zero
    a_r9_ref_nonzero: assert property (@(posedge clk) disable iff (rst)
        r_left != '0);

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider import psd_pkg::*; #(
    parameter int PRE_LOG = 6,
    parameter int A_W     = 7,
    parameter int N_W     = 11,
    parameter int R_W     = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_ce,
    input  logic           cfg_narrow,
    input  logic [A_W-1:0] cfg_swallow,
    input  logic [N_W-1:0] cfg_main,
    input  logic [R_W-1:0] cfg_ref,
    output logic           fp,
    output logic           fr,
    output logic           swallow_clamped
);
    logic           clamp_req;
    logic [A_W-1:0] a_eff;
    logic           swallow;
    logic           turn_done;
    pre_mode_e      act_mode;

    // Clamp A to N-1 when it would not fit below N.
    assign clamp_req = int'(cfg_swallow) >= int'(cfg_main);
    assign a_eff     = clamp_req ? A_W'(cfg_main - N_W'(1)) : cfg_swallow;

    psd_prescaler #(.PRE_LOG(PRE_LOG)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .mode      (act_mode),
        .swallow   (swallow),
        .turn_done (turn_done)
    );

    psd_swallow_ctr #(.A_W(A_W), .N_W(N_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .turn_done    (turn_done),
        .ld_mode      (pre_mode_e'(cfg_narrow)),
        .ld_clamped   (clamp_req),
        .ld_a         (a_eff),
        .ld_n         (cfg_main),
        .swallow      (swallow),
        .mode         (act_mode),
        .clamped      (swallow_clamped),
        .period_pulse (fp)
    );

    psd_ref_ctr #(.R_W(R_W)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .tick      (ref_ce),
        .ld_r      (cfg_ref),
        .ref_pulse (fr)
    );

    // R1: outputs quiet while in reset
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        $past(rst) |-> (!fp && !fr));

endmodule

// File: tb/test_swallow_divider.sv
module test_swallow_divider;
    localparam int PL = 2;
    localparam int AW = 3;
    localparam int NW = 4;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_ce = 1'b0;
    logic          cfg_narrow = 1'b1;
    logic [AW-1:0] cfg_swallow = '0;
    logic [NW-1:0] cfg_main = NW'(3);
    logic [RW-1:0] cfg_ref = RW'(3);
    logic          fp, fr, swallow_clamped;

    int checks = 0;
    int errs = 0;
    int ce_mode = 0;   // 0 off, 1 always, 2 every third clock

    always #5 clk = ~clk;

    swallow_divider #(.PRE_LOG(PL), .A_W(AW), .N_W(NW), .R_W(RW)) i_swallow_divider (
        .clk(clk), .rst(rst), .ref_ce(ref_ce), .cfg_narrow(cfg_narrow),
        .cfg_swallow(cfg_swallow), .cfg_main(cfg_main), .cfg_ref(cfg_ref),
        .fp(fp), .fr(fr), .swallow_clamped(swallow_clamped)
    );

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph == 2) ? 0 : ph + 1;
            ref_ce = (ce_mode == 1) || (ce_mode == 2 && ph == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!fp && !fr, "R1 outputs low in reset", {fp, fr}, 0);
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic wait_fp(output int k);
        k = 0;
        do begin
            @(posedge clk); k++;
            @(negedge clk);
        end while (!fp && k < 4000);
    endtask

    task automatic wait_fr(output int ticks);
        ticks = 0;
        do begin
            @(posedge clk); if (ref_ce) ticks++;
            @(negedge clk);
        end while (!fr && ticks < 4000);
    endtask

    function automatic int expect_len(int narrow, int n, int a);
        int p, ae;
        p  = narrow ? (1 << PL) : (1 << (PL + 1));
        ae = (a >= n) ? n - 1 : a;
        return p * n + ae;
    endfunction

    initial begin
        int k, len;
        // R2 R3 R4 R5 R7: sweep every legal ratio of the small configuration
        for (int sel = 0; sel < 2; sel++) begin
            for (int n = 3; n < (1 << NW); n++) begin
                for (int a = 0; a < (1 << AW); a++) begin
                    cfg_narrow = sel[0]; cfg_main = NW'(n); cfg_swallow = AW'(a);
                    len = expect_len(sel, n, a);
                    do_reset();
                    check(swallow_clamped == (a >= n), "R5 clamp flag", swallow_clamped, a >= n);
                    wait_fp(k);
                    check(k == len, "R7 first pulse delay", k, len);
                    @(posedge clk); @(negedge clk);
                    check(!fp, "R4 pulse width", fp, 0);
                    wait_fp(k);
                    check(k + 1 == len, "R3 period length (R2 modulus)", k + 1, len);
                end
            end
        end

        // R6: mid-period change applies from the next period
        cfg_narrow = 1'b1; cfg_main = NW'(5); cfg_swallow = AW'(2);
        do_reset();
        wait_fp(k);
        repeat (3) begin @(posedge clk); @(negedge clk); end
        cfg_narrow = 1'b0; cfg_main = NW'(3); cfg_swallow = AW'(7);
        check(!swallow_clamped, "R6 flag held mid period", swallow_clamped, 0);
        wait_fp(k);
        check(k + 3 == 22, "R6 running period keeps old ratio", k + 3, 22);
        check(swallow_clamped, "R6 flag updates at boundary", swallow_clamped, 1);
        wait_fp(k);
        check(k == 26, "R6 next period uses new ratio", k, 26);

        // R8: reference divider, tick every clock
        ce_mode = 1;
        for (int r = 3; r < (1 << RW); r++) begin
            cfg_ref = RW'(r);
            do_reset();
            wait_fr(k);
            check(k == r, "R8 first reference pulse", k, r);
            @(posedge clk); @(negedge clk);
            check(!fr, "R8 reference pulse width", fr, 0);
            wait_fr(k);
            check(k + 1 == r, "R8 reference period", k + 1, r);
        end

        // R8: ticks every third clock
        ce_mode = 2;
        for (int r = 3; r < 10; r++) begin
            cfg_ref = RW'(r);
            do_reset();
            wait_fr(k);
            check(k == r, "R8 gated tick count", k, r);
            wait_fr(k);
            check(k == r, "R8 gated period", k, r);
        end

        // R9: reference ratio change waits for the boundary
        ce_mode = 1;
        cfg_ref = RW'(5);
        do_reset();
        wait_fr(k);
        repeat (2) begin @(posedge clk); @(negedge clk); end
        cfg_ref = RW'(9);
        wait_fr(k);
        check(k + 2 == 5, "R9 running reference period", k + 2, 5);
        wait_fr(k);
        check(k == 9, "R9 new reference period", k, 9);

        // R10: no ticks, no reference pulse
        ce_mode = 0;
        cfg_ref = RW'(3);
        do_reset();
        k = 0;
        repeat (60) begin
            @(posedge clk); @(negedge clk);
            if (fr) k++;
        end
        check(k == 0, "R10 fr quiet without ticks", k, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

endmodule